// File: doc/BRIEF.md
# Branch Target Address Generator

This unit owns the program counter of a small 8-bit controller with a 16-bit code address space and decides, on every instruction, where execution continues. Each cycle it is told how long the current instruction is, which kind of jump (if any) the instruction performs, whether that jump is taken, and which operand bytes the fetch logic captured. From these it forms either the plain sequential address or one of five branch targets, and loads the chosen value into the PC when the pipeline advances.

Every target is formed from the already-advanced PC, which is the current PC plus the instruction length. A relative jump adds a sign-extended byte to it. A page jump keeps its top five bits and splices in eleven bits carried by the instruction. A long jump replaces the whole address. The two indexed forms add the unsigned accumulator either to the data pointer or to the advanced PC. All arithmetic wraps at 64 KB and raises no flag. The next address is also exposed combinationally so that fetch can start on it before the PC register updates.

Top module: `pcNextUnit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pcOut` becomes 0000h at that edge, whatever the other inputs are.
- R2: With `take` low, or with `jumpKind` = 0 (sequential), `nextPc` equals `pcOut` plus `instrLen`, where `instrLen` takes the values 1, 2 or 3.
- R3: When `advance` is low (and `rst` low), `pcOut` keeps its value across the clock edge; when `advance` is high, `pcOut` takes the value `nextPc` showed before the edge.
- R4: A taken relative jump (`jumpKind` = 1) gives the advanced PC plus the sign-extended offset byte (-128 to +127); the offset is `opByteB` when `instrLen` is 3 and `opByteA` otherwise.
- R5: A taken page jump (`jumpKind` = 2) gives bits 15:11 of the advanced PC, then `pageBits` as bits 10:8, then `opByteA` as bits 7:0; the upper five bits come from the advanced PC, not from the address of the jump itself.
- R6: A taken long jump (`jumpKind` = 3) gives `opByteA` as the high byte and `opByteB` as the low byte of the target.
- R7: A taken data-pointer indexed jump (`jumpKind` = 4) gives `dataPtr` plus `accum` taken as unsigned.
- R8: A taken PC-indexed jump (`jumpKind` = 5) gives the advanced PC plus `accum` taken as unsigned.
- R9: All address sums wrap modulo 65536 with no flag, for the sequential, relative and indexed forms alike.
- R10: The `jumpKind` codes 6 and 7 are reserved and behave as sequential even when `take` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Load `nextPc` into the PC at this edge |
| instrLen | input | 2 | Length in bytes of the current instruction (1 to 3) |
| jumpKind | input | 3 | Jump form: 0 seq, 1 relative, 2 page, 3 long, 4 index data pointer, 5 index PC, 6-7 reserved |
| take | input | 1 | Branch condition met; low forces the sequential address |
| opByteA | input | 8 | Second instruction byte |
| opByteB | input | 8 | Third instruction byte |
| pageBits | input | 3 | Target bits 10:8 carried in the opcode of a page jump |
| accum | input | 8 | Accumulator value used as unsigned index |
| dataPtr | input | 16 | Data pointer used as index base |
| pcOut | output | 16 | Current program counter |
| nextPc | output | 16 | Address the PC takes at the next advancing edge |

## Verification
The hardest situations to reach are those where the advanced PC differs from the jump's own address in a way that changes the result: a page jump whose opcode sits just below a 2 KB boundary, and relative or indexed sums that wrap through FFFFh. The stimulus first places the PC exactly with a long jump (to 07FFh and FFFFh, for example) and then issues the jump under test, so the page-boundary splice and the wrap are both observed at `nextPc` and at `pcOut`. Reserved jump codes and untaken branches are driven with operand bytes that would produce a distinct target, so a wrong selection shows up as a wrong address.

// File: rtl/pcNextPkg.sv
package pcNextPkg;

  typedef enum logic [2:0] {
    JK_SEQ      = 3'd0,
    JK_REL      = 3'd1,
    JK_PAGE     = 3'd2,
    JK_LONG     = 3'd3,
    JK_IDX_DATA = 3'd4,
    JK_IDX_PC   = 3'd5,
    JK_RSV6     = 3'd6,
    JK_RSV7     = 3'd7
  } jumpKindE;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPc;
    logic selSeq;
    logic selRel;
    logic selPage;
    logic selLong;
    logic selIdx;
    logic idxFromPc;
    logic offFromLast;
  } pcStrobesT;

endpackage

// File: rtl/pcNextCtrl.sv
module pcNextCtrl
  import pcNextPkg::*;
#(
  parameter int LEN_W  = 2,
  parameter int KIND_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              take,
  input  logic [KIND_W-1:0] jumpKind,
  input  logic [LEN_W-1:0]  instrLen,
  output pcStrobesT         strobes
);

  localparam logic [LEN_W-1:0] LAST_IS_B = LEN_W'(3);

  jumpKindE kind;
  logic     branchTaken;

  assign kind = jumpKindE'(jumpKind);

  always_comb begin
    branchTaken = take;
    unique case (kind)
      JK_SEQ, JK_RSV6, JK_RSV7: branchTaken = 1'b0;
      default:                  branchTaken = take;
    endcase
  end

  always_comb begin
    strobes             = '0;
    strobes.loadPc      = advance;
    strobes.offFromLast = (instrLen == LAST_IS_B);
    strobes.idxFromPc   = (kind == JK_IDX_PC);
    if (!branchTaken) begin
      strobes.selSeq = 1'b1;
    end else begin
      unique case (kind)
        JK_REL:               strobes.selRel  = 1'b1;
        JK_PAGE:              strobes.selPage = 1'b1;
        JK_LONG:              strobes.selLong = 1'b1;
        JK_IDX_DATA, JK_IDX_PC: strobes.selIdx = 1'b1;
        default:              strobes.selSeq  = 1'b1;
      endcase
    end
  end

  // R10
  reserved_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (jumpKind >= KIND_W'(6)) |-> strobes.selSeq);

  // R2
  untaken_seq_chk: assert property (@(posedge clk) disable iff (rst)
    !take |-> (strobes.selSeq && !strobes.selRel && !strobes.selLong));

endmodule

// File: rtl/pcNextPath.sv
module pcNextPath
  import pcNextPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 11,
  parameter int LEN_W     = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  pcStrobesT                     strobes,
  input  logic [LEN_W-1:0]              instrLen,
  input  logic [DATA_W-1:0]             opByteA,
  input  logic [DATA_W-1:0]             opByteB,
  input  logic [PAGE_BITS-DATA_W-1:0]   pageBits,
  input  logic [DATA_W-1:0]             accum,
  input  logic [ADDR_W-1:0]             dataPtr,
  output logic [ADDR_W-1:0]             pcOut,
  output logic [ADDR_W-1:0]             nextPc
);

  localparam int KEEP_W = ADDR_W - PAGE_BITS;
  localparam int EXT_W  = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] PC_RESET = '0;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] relTarget;
  logic [ADDR_W-1:0] pageTarget;
  logic [ADDR_W-1:0] longTarget;
  logic [ADDR_W-1:0] idxBase;
  logic [ADDR_W-1:0] idxTarget;
  logic [DATA_W-1:0] relOffset;

  // Advanced PC: every target is built on it
  assign seqPc = pcReg + {{(ADDR_W-LEN_W){1'b0}}, instrLen};

  assign relOffset = strobes.offFromLast ? opByteB : opByteA;
  assign relTarget = seqPc + {{EXT_W{relOffset[DATA_W-1]}}, relOffset};

  assign pageTarget = {seqPc[ADDR_W-1:PAGE_BITS], pageBits, opByteA};

  assign longTarget = ADDR_W'({opByteA, opByteB});

  assign idxBase   = strobes.idxFromPc ? seqPc : dataPtr;
  assign idxTarget = idxBase + {{EXT_W{1'b0}}, accum};

  always_comb begin
    nextPc = seqPc;
    if (strobes.selRel)  nextPc = relTarget;
    if (strobes.selPage) nextPc = pageTarget;
    if (strobes.selLong) nextPc = longTarget;
    if (strobes.selIdx)  nextPc = idxTarget;
  end

  always_ff @(posedge clk) begin
    if (rst)                 pcReg <= PC_RESET;
    else if (strobes.loadPc) pcReg <= nextPc;
  end

  assign pcOut = pcReg;

  // R1
  reset_pc_chk: assert property (@(posedge clk)
    rst |=> (pcOut == PC_RESET));

  // R3
  hold_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadPc |=> $stable(pcOut));

  // R3
  load_pc_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.loadPc |=> (pcOut == $past(nextPc)));

  // R2
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({strobes.selSeq, strobes.selRel, strobes.selPage,
             strobes.selLong, strobes.selIdx}));

  // R5
  page_keep_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.selPage |-> (nextPc[ADDR_W-1:PAGE_BITS] == seqPc[ADDR_W-1:PAGE_BITS]));

  // R9
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.selSeq |-> ((nextPc - pcOut) == {{(ADDR_W-LEN_W){1'b0}}, instrLen}));

endmodule

// File: rtl/pcNextUnit.sv
module pcNextUnit
  import pcNextPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 11,
  parameter int LEN_W     = 2,
  parameter int KIND_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        advance,
  input  logic [LEN_W-1:0]            instrLen,
  input  logic [KIND_W-1:0]           jumpKind,
  input  logic                        take,
  input  logic [DATA_W-1:0]           opByteA,
  input  logic [DATA_W-1:0]           opByteB,
  input  logic [PAGE_BITS-DATA_W-1:0] pageBits,
  input  logic [DATA_W-1:0]           accum,
  input  logic [ADDR_W-1:0]           dataPtr,
  output logic [ADDR_W-1:0]           pcOut,
  output logic [ADDR_W-1:0]           nextPc
);

  pcStrobesT strobes;

  pcNextCtrl #(
    .LEN_W  (LEN_W),
    .KIND_W (KIND_W)
  ) ctrl (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .take     (take),
    .jumpKind (jumpKind),
    .instrLen (instrLen),
    .strobes  (strobes)
  );

  pcNextPath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BITS (PAGE_BITS),
    .LEN_W     (LEN_W)
  ) path (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .instrLen (instrLen),
    .opByteA  (opByteA),
    .opByteB  (opByteB),
    .pageBits (pageBits),
    .accum    (accum),
    .dataPtr  (dataPtr),
    .pcOut    (pcOut),
    .nextPc   (nextPc)
  );

endmodule

// File: tb/pcNextUnit_test.sv
module pcNextUnit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advance = 1'b0;
  logic [1:0]  instrLen = 2'd1;
  logic [2:0]  jumpKind = 3'd0;
  logic        take = 1'b0;
  logic [7:0]  opByteA = '0;
  logic [7:0]  opByteB = '0;
  logic [2:0]  pageBits = '0;
  logic [7:0]  accum = '0;
  logic [15:0] dataPtr = '0;
  logic [15:0] pcOut;
  logic [15:0] nextPc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] modelPc = 16'h0000;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcNextUnit uut (
    .clk(clk), .rst(rst), .advance(advance), .instrLen(instrLen),
    .jumpKind(jumpKind), .take(take), .opByteA(opByteA), .opByteB(opByteB),
    .pageBits(pageBits), .accum(accum), .dataPtr(dataPtr),
    .pcOut(pcOut), .nextPc(nextPc)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected target from the requirement text
  function automatic logic [15:0] expectTarget(input logic [15:0] pc, input logic [1:0] len,
      input logic [2:0] kind, input logic tk, input logic [7:0] a, input logic [7:0] b,
      input logic [2:0] pg, input logic [7:0] acc, input logic [15:0] dp);
    logic [15:0] adv;
    logic [7:0]  off;
    adv = pc + 16'(len);
    off = (len == 2'd3) ? b : a;
    if (!tk) return adv;
    case (kind)
      3'd1: return adv + {{8{off[7]}}, off};
      3'd2: return {adv[15:11], pg, a};
      3'd3: return {a, b};
      3'd4: return dp + 16'(acc);
      3'd5: return adv + 16'(acc);
      default: return adv;
    endcase
  endfunction

  // Driver: apply one instruction, check the comb output, queue the PC result
  task automatic step(input string tag, input logic adv, input logic [1:0] len,
      input logic [2:0] kind, input logic tk, input logic [7:0] a, input logic [7:0] b,
      input logic [2:0] pg, input logic [7:0] acc, input logic [15:0] dp);
    logic [15:0] exp;
    @(negedge clk);
    rst = 1'b0; advance = adv; instrLen = len; jumpKind = kind; take = tk;
    opByteA = a; opByteB = b; pageBits = pg; accum = acc; dataPtr = dp;
    #1;
    exp = expectTarget(modelPc, len, kind, tk, a, b, pg, acc, dp);
    check({tag, " nextPc"}, nextPc, exp);
    if (adv) modelPc = exp;
    expQ.push_back(modelPc);
    tagQ.push_back({tag, " pcOut"});
  endtask

  task automatic doReset(input string tag);
    @(negedge clk);
    rst = 1'b1; advance = 1'b1; take = 1'b1; jumpKind = 3'd3;
    opByteA = 8'hAB; opByteB = 8'hCD;
    modelPc = 16'h0000;
    expQ.push_back(16'h0000);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare each registered PC after its edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, pcOut, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset value", pcOut, 16'h0000);
    // R2 sequential lengths
    step("R2 len1", 1, 2'd1, 3'd0, 1, 8'h55, 8'h66, 3'd7, 8'h00, 16'h0000);
    step("R2 len3", 1, 2'd3, 3'd0, 0, 8'h55, 8'h66, 3'd7, 8'h00, 16'h0000);
    step("R2 len2 untaken long", 1, 2'd2, 3'd3, 0, 8'h12, 8'h34, 3'd0, 8'h00, 16'h0000);
    // R3 hold
    step("R3 hold", 0, 2'd2, 3'd3, 1, 8'h77, 8'h77, 3'd0, 8'h00, 16'h0000);
    step("R3 hold again", 0, 2'd1, 3'd0, 0, 8'h00, 8'h00, 3'd0, 8'h00, 16'h0000);
    // R4 relative forward, backward with wrap, last byte for len 3
    step("R4 rel fwd", 1, 2'd2, 3'd1, 1, 8'h10, 8'hEE, 3'd0, 8'h00, 16'h0000);
    step("R4 R9 rel back wrap", 1, 2'd2, 3'd1, 1, 8'h80, 8'h00, 3'd0, 8'h00, 16'h0000);
    step("R4 rel len3 byteB", 1, 2'd3, 3'd1, 1, 8'hF0, 8'h05, 3'd0, 8'h00, 16'h0000);
    step("R4 rel max", 1, 2'd2, 3'd1, 1, 8'h7F, 8'h00, 3'd0, 8'h00, 16'h0000);
    // R6 long
    step("R6 long", 1, 2'd3, 3'd3, 1, 8'h12, 8'h34, 3'd0, 8'h00, 16'h0000);
    // R5 page jump within page
    step("R5 page", 1, 2'd2, 3'd2, 1, 8'h67, 8'h00, 3'b101, 8'h00, 16'h0000);
    // R5 page boundary: opcode at 07FFh, advanced PC in next page
    step("R6 long to 07FF", 1, 2'd3, 3'd3, 1, 8'h07, 8'hFF, 3'd0, 8'h00, 16'h0000);
    step("R5 page boundary", 1, 2'd2, 3'd2, 1, 8'h10, 8'h00, 3'd0, 8'h00, 16'h0000);
    // R7 data pointer index with wrap
    step("R7 R9 idx data wrap", 1, 2'd1, 3'd4, 1, 8'h00, 8'h00, 3'd0, 8'h20, 16'hFFF0);
    // R8 PC index
    step("R8 idx pc", 1, 2'd1, 3'd5, 1, 8'h00, 8'h00, 3'd0, 8'hFF, 16'h4000);
    // R10 reserved codes
    step("R10 kind6", 1, 2'd1, 3'd6, 1, 8'h99, 8'h88, 3'd7, 8'hFF, 16'h8000);
    step("R10 kind7", 1, 2'd2, 3'd7, 1, 8'h99, 8'h88, 3'd7, 8'hFF, 16'h8000);
    // R9 sequential wrap through FFFFh
    step("R6 long to FFFF", 1, 2'd3, 3'd3, 1, 8'hFF, 8'hFF, 3'd0, 8'h00, 16'h0000);
    step("R9 seq wrap", 1, 2'd1, 3'd0, 0, 8'h00, 8'h00, 3'd0, 8'h00, 16'h0000);
    step("R6 long to 2222", 1, 2'd3, 3'd3, 1, 8'h22, 8'h22, 3'd0, 8'h00, 16'h0000);
    // R1 reset overrides a taken load
    doReset("R1 reset over load");
    step("R2 after reset", 1, 2'd1, 3'd0, 0, 8'h00, 8'h00, 3'd0, 8'h00, 16'h0000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule